// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block collects a parameterized set of peripheral interrupt request lines and reduces them to one registered request for a processor core. Each line has a pending bit in a status register and an enable bit in a mask register. The core request is raised whenever at least one pending line is also enabled. Both registers are reached through a small register port with a one-bit address, a one-cycle write strobe and a combinational read path.

A static configuration input chooses how every line is sensed. In edge mode a rising request latches a pending bit, and only software can clear that bit by writing a zero to it. In level mode the pending bits follow the synchronized request lines, and software writes to the status register are dropped. A second configuration input keeps the two lowest lines permanently enabled. Those lines gain no priority from this. Software decides the order in which pending lines are served.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the status register reads all zeros, the stored mask reads all zeros (bits 1:0 read 1 while the lock input is high), and `core_irq` is 0.
- R2: A request line that rises from 0 to 1 is visible as a pending status bit on the third rising clock edge after the change, and `core_irq` follows one edge later if that line is enabled.
- R3: In edge mode (`cfg_edge`=1) a pending bit stays set until software writes 0 to that bit of the status register. Writing 1 to a status bit has no effect.
- R4: In level mode (`cfg_edge`=0) each status bit follows its synchronized request line, and writes to the status register have no effect.
- R5: While a status bit is set, further rising edges on the same line are not counted, so one clearing write leaves the bit at 0.
- R6: While `cfg_lock_low` is 1, mask bits 0 and 1 read as 1 and are treated as enabled even after a write of 0. While it is 0, those bits behave like every other mask bit.
- R7: A pending line whose mask bit is 0 does not raise `core_irq`, but its status bit still reads as 1.
- R8: If a clearing write and a new rising edge reach the same status bit on the same clock edge, the bit remains set.
- R9: Address 0 selects the mask register and address 1 selects the status register. `reg_rdata` shows the selected register in the same cycle.
- R10: A mask write takes effect on the next clock edge, and `core_irq` reflects the new mask one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_edge | input | 1 | 1 selects edge sensing, 0 selects level sensing |
| cfg_lock_low | input | 1 | 1 keeps lines 0 and 1 always enabled |
| irq_lines | input | NUM_LINES | Peripheral request lines (asynchronous) |
| reg_we | input | 1 | One-cycle write strobe |
| reg_addr | input | 1 | 0 selects the mask register, 1 selects the status register |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Read data for the selected register |
| core_irq | output | 1 | Registered interrupt request to the core |

## Verification
The hardest case to reach is a clearing write that lands on the same clock edge as a fresh rising edge on the same line. That edge only exists after the two-flop synchronizer and the previous-value compare. The bench first pends the line and drops it. It then raises the line again and issues the status write exactly two edges later, so both events meet at the status flop. The case where a request is ignored while its bit is set is checked by pulsing a pended line a second time and showing that a single write returns the bit to zero.

// File: rtl/irq_mask_pkg.sv
// Package: shared constants and the register select type for the interrupt
// controller. Assumes the locked low lines are the two lowest indices.
package irq_mask_pkg;
    localparam int LOCKED_LINES = 2;

    typedef enum logic {
        SEL_MASK   = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_line_sync.sv
// Module: two-or-more flop synchronizer, one chain per request line.
// Assumes inputs are asynchronous single-bit levels; reset clears the chain.
module irq_line_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            // Shift the raw level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in[g]};
            end
            assign sync_out[g] = chain_q[LAST];
        end
    endgenerate
endmodule

// File: rtl/irq_pend_reg.sv
// Module: pending status register. Edge mode latches rising edges until
// software writes 0; level mode follows the synchronized lines and drops
// writes. Assumes sync_in is already in the clk domain.
module irq_pend_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_mode,
    input  logic [WIDTH-1:0] sync_in,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] pend_q
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] keep;

    assign rise = sync_in & ~prev_q;
    // A write clears bits whose data is 0; a new edge overrides the clear.
    assign keep = wr_en ? (pend_q & wr_data) : pend_q;

    // Remember last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    // Update pending bits according to the sensing mode.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= '0;
        else if (edge_mode) pend_q <= keep | rise;
        else                pend_q <= sync_in;
    end

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(edge_mode) && !$past(wr_en))
            |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(edge_mode)) |-> (pend_q == $past(sync_in)));
endmodule

// File: rtl/irq_enable_reg.sv
// Module: mask register with optional forcing of the lowest lines to enabled.
// Assumes WIDTH is at least LOCKED_LINES.
module irq_enable_reg
    import irq_mask_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_low,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] mask_eff
);
    logic [WIDTH-1:0] mask_q;

    // Store the software-written enables.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            if (g < LOCKED_LINES) begin : g_locked
                assign mask_eff[g] = mask_q[g] | lock_low;
            end else begin : g_free
                assign mask_eff[g] = mask_q[g];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_mask_ctrl.sv
// Module: top of the maskable interrupt controller. Synchronizes request
// lines, keeps status and mask, and raises a registered core request.
// Assumes configuration inputs are static between software sequences.
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_edge,
    input  logic                 cfg_lock_low,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_we,
    input  logic                 reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 core_irq
);
    reg_sel_e             sel;
    logic [NUM_LINES-1:0] lines_s;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] mask_eff;
    logic                 wr_pend;
    logic                 wr_mask;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_pend = reg_we && (sel == SEL_STATUS);
    assign wr_mask = reg_we && (sel == SEL_MASK);

    irq_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_lines), .sync_out(lines_s)
    );

    irq_pend_reg #(.WIDTH(NUM_LINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .edge_mode(cfg_edge), .sync_in(lines_s),
        .wr_en(wr_pend), .wr_data(reg_wdata), .pend_q(pend)
    );

    irq_enable_reg #(.WIDTH(NUM_LINES)) u_mask (
        .clk(clk), .rst_n(rst_n), .lock_low(cfg_lock_low), .wr_en(wr_mask),
        .wr_data(reg_wdata), .mask_eff(mask_eff)
    );

    // Select the register shown on the read port.
    always_comb begin
        if (sel == SEL_STATUS) reg_rdata = pend;
        else                   reg_rdata = mask_eff;
    end

    // Register the combined request toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) core_irq <= 1'b0;
        else        core_irq <= |(pend & mask_eff);
    end

    // R2
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && core_irq) |-> ($past(pend) != '0));

    // R6
    lock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock_low && reg_addr == 1'b0) |-> (reg_rdata[1:0] == 2'b11));
endmodule

// File: tb/sim_irq_mask_ctrl.sv
module sim_irq_mask_ctrl;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_edge = 1'b1;
    logic         cfg_lock_low = 1'b0;
    logic [N-1:0] irq_lines = '0;
    logic         reg_we = 1'b0;
    logic         reg_addr = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         core_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_ctrl #(.NUM_LINES(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_edge(cfg_edge),
        .cfg_lock_low(cfg_lock_low), .irq_lines(irq_lines), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_irq(core_irq)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [N-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic a, input logic [N-1:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_lines = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        cfg_edge = 1'b1; cfg_lock_low = 1'b0;
        do_reset();
        rd(1'b1, v); chk("R1 status", v, '0);
        rd(1'b0, v); chk("R1 mask", v, '0);
        chk("R1 core_irq", {31'b0, core_irq}, 32'd0);
    endtask

    task automatic t_edge_latency();
        logic [N-1:0] v;
        wr(1'b0, 32'h0000_0010);
        irq_lines[4] = 1'b1;
        step(2);
        rd(1'b1, v); chk("R2 not yet pending", v, '0);
        step(1);
        rd(1'b1, v); chk("R2 pending after 3 edges", v, 32'h10);
        chk("R2 irq not yet", {31'b0, core_irq}, 32'd0);
        step(1);
        chk("R2 core_irq", {31'b0, core_irq}, 32'd1);
        irq_lines[4] = 1'b0;
        step(4);
        rd(1'b1, v); chk("R3 sticky after line low", v, 32'h10);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); chk("R3 write 1 no effect", v, 32'h10);
        wr(1'b1, ~32'h10);
        rd(1'b1, v); chk("R3 write 0 clears", v, '0);
        step(1);
        chk("R3 core_irq drops", {31'b0, core_irq}, 32'd0);
    endtask

    task automatic t_ignore_repeat();
        logic [N-1:0] v;
        irq_lines[7] = 1'b1; step(3); irq_lines[7] = 1'b0; step(3);
        irq_lines[7] = 1'b1; step(3); irq_lines[7] = 1'b0; step(3);
        rd(1'b1, v); chk("R5 pending once", v, 32'h80);
        wr(1'b1, ~32'h80);
        step(3);
        rd(1'b1, v); chk("R5 single clear suffices", v, '0);
    endtask

    task automatic t_mask();
        logic [N-1:0] v;
        wr(1'b0, '0);
        irq_lines[9] = 1'b1;
        step(5);
        rd(1'b1, v); chk("R7 status visible while masked", v, 32'h200);
        chk("R7 core_irq stays low", {31'b0, core_irq}, 32'd0);
        wr(1'b0, 32'h200);
        rd(1'b0, v); chk("R9 mask readback", v, 32'h200);
        chk("R10 irq not before next edge", {31'b0, core_irq}, 32'd0);
        step(1);
        chk("R10 irq after mask write", {31'b0, core_irq}, 32'd1);
        irq_lines[9] = 1'b0;
        wr(1'b1, '0);
        step(2);
        chk("R10 irq low after clear", {31'b0, core_irq}, 32'd0);
    endtask

    task automatic t_same_cycle();
        logic [N-1:0] v;
        irq_lines[12] = 1'b1; step(3); irq_lines[12] = 1'b0; step(3);
        rd(1'b1, v); chk("R8 setup pending", v, 32'h1000);
        irq_lines[12] = 1'b1;
        step(2);
        wr(1'b1, ~32'h1000);
        rd(1'b1, v); chk("R8 edge beats clear", v, 32'h1000);
        irq_lines[12] = 1'b0;
        wr(1'b1, '0);
        rd(1'b1, v); chk("R8 later clear works", v, '0);
    endtask

    task automatic t_level();
        logic [N-1:0] v;
        cfg_edge = 1'b0;
        step(4);
        irq_lines[3] = 1'b1;
        step(3);
        rd(1'b1, v); chk("R4 follows high", v, 32'h8);
        wr(1'b1, '0);
        rd(1'b1, v); chk("R4 write ignored", v, 32'h8);
        irq_lines[3] = 1'b0;
        step(3);
        rd(1'b1, v); chk("R4 follows low", v, '0);
        cfg_edge = 1'b1;
        step(2);
    endtask

    task automatic t_lock();
        logic [N-1:0] v;
        wr(1'b0, '0);
        cfg_lock_low = 1'b1;
        #1;
        rd(1'b0, v); chk("R6 low bits forced", v, 32'h3);
        wr(1'b0, '0);
        rd(1'b0, v); chk("R6 write 0 does not stick", v, 32'h3);
        irq_lines[0] = 1'b1;
        step(4);
        chk("R6 locked line raises irq", {31'b0, core_irq}, 32'd1);
        irq_lines[0] = 1'b0;
        wr(1'b1, '0);
        cfg_lock_low = 1'b0;
        #1;
        rd(1'b0, v); chk("R6 lock off bits free", v, '0);
        irq_lines[1] = 1'b1;
        step(5);
        chk("R6 unlocked line masked", {31'b0, core_irq}, 32'd0);
        irq_lines[1] = 1'b0;
        wr(1'b1, '0);
    endtask

    initial begin
        t_reset();
        t_edge_latency();
        t_ignore_repeat();
        t_mask();
        t_same_cycle();
        t_level();
        t_lock();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule